// File: doc/BRIEF.md
# Load-Use Interlock and Branch Squash Unit

This unit makes the stall and fetch-control decisions for an in-order pipeline with eight stages. Instruction fetch is split over two stages (`F1`, `F2`). Decode and operand read take one stage (`RD`). Execute takes one (`EX`). The data-cache access is split over two stages (`M1`, `M2`), and a tag-check stage and a writeback stage follow. Load data becomes available only at the end of `M2`. An instruction in `RD` that reads the destination of a load still in `EX` or `M1` therefore cannot proceed. The unit holds `F1`, `F2` and `RD` and sends bubbles into `EX` until the load has left `M1`. Other producers are served by forwarding and never cause a stall.

Branches resolve in `EX`, where both the condition and the target are known. The slot right after a branch always executes. At resolution time that slot is in `RD`. Fetch always continues down the sequential path. When a branch resolves taken, the two younger instructions in `F2` and `F1` are wrong-path, so the unit marks them for squashing and redirects the PC to the target in the same cycle. This gives a penalty of two cycles on top of the delay slot. A branch that is not taken costs nothing beyond the slot.

The unit's decisions are combinational. The surrounding pipeline registers apply them at the next clock edge. Because a held consumer is re-checked every cycle while the load moves on, a consumer directly behind a load waits two cycles and a consumer one instruction later waits one cycle.

Top module: `ilk_unit`

## Requirements
- R1: When `rd_valid` is high and a nonzero source register of `RD` equals `ex_dst` of a valid load in `EX`, `stall` is high in that cycle.
- R2: When `rd_valid` is high and a nonzero source register of `RD` equals `m1_dst` of a valid load in `M1`, `stall` is high in that cycle.
- R3: A source register equal to 0 never raises `stall`, even when a valid load in `EX` or `M1` writes register 0.
- R4: A producer whose load flag is low, or whose valid bit is low, never raises `stall`, even when its destination matches a source of `RD`.
- R5: While `rd_valid` is low, `stall` is low whatever the producers hold.
- R6: Each of the `NUM_SRC` source fields of `RD` is checked independently. Field k occupies bits `[k*REG_W +: REG_W]` of `rd_srcs`, and a match on any one field raises `stall`.
- R7: When `ex_valid`, `ex_branch` and `ex_taken` are all high, then in the same cycle `squash` is `2'b11` (bit 0 = `F1`, bit 1 = `F2`), `redir_valid` is high and `redir_pc` equals `ex_target`. The delay slot in `RD` has no squash bit and is never killed.
- R8: In any other case `squash` is `2'b00` and `redir_valid` is low. A branch never affects `stall` by itself.
- R9: When the pipeline holds `RD` while `stall` is high and advances the load one stage per cycle, a consumer directly behind a load sees exactly 2 stall cycles. A consumer one instruction behind it sees exactly 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Decode stage holds an instruction |
| rd_srcs | input | NUM_SRC*REG_W | Source register fields of the decode instruction |
| ex_valid | input | 1 | EX stage holds an instruction |
| ex_load | input | 1 | EX instruction is a load |
| ex_dst | input | REG_W | EX destination register |
| m1_valid | input | 1 | First data-fetch stage holds an instruction |
| m1_load | input | 1 | That instruction is a load |
| m1_dst | input | REG_W | Its destination register |
| ex_branch | input | 1 | EX instruction is a branch |
| ex_taken | input | 1 | Branch condition resolved true |
| ex_target | input | PC_W | Branch target address |
| stall | output | 1 | Hold F1, F2, RD; insert bubble into EX |
| squash | output | 2 | Invalidate F1 (bit 0) and F2 (bit 1) |
| redir_valid | output | 1 | Load PC with `redir_pc` |
| redir_pc | output | PC_W | Redirect address |

## Verification
The bench aims at register 0, because a design that treated it as a normal register would stall behind a load that writes r0. It drives matching destinations on non-load and invalid producers, which a design with a missing load or valid qualifier would wrongly stall on. It puts the match only in the second source field, so an unrolling that checks one field would miss the stall. It also runs load-use sequences with distances 1 and 2 against a small pipeline model, where a missing `M1` comparison shows up as one stall instead of two. Finally, it checks that a taken branch kills `F1` and `F2` but never the delay slot, and that a not-taken branch leaves fetch untouched.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  // squash mask bit positions
  localparam int SQ_F1 = 0;
  localparam int SQ_F2 = 1;
  localparam int SQ_W  = 2;
  // producer stages compared against decode
  localparam int PROD_EX = 0;
  localparam int PROD_M1 = 1;
  localparam int NUM_PROD = 2;
endpackage

// File: rtl/ilk_hazard.sv
module ilk_hazard
  import ilk_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_valid,
  input  logic [NUM_SRC*REG_W-1:0] rd_srcs,
  input  logic [NUM_PROD-1:0]      p_valid,
  input  logic [NUM_PROD-1:0]      p_load,
  input  logic [NUM_PROD*REG_W-1:0] p_dst,
  output logic                     stall
);
  localparam int NPAIR = NUM_SRC * NUM_PROD;

  logic [NPAIR-1:0] hit;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
      logic [REG_W-1:0] src_r, dst_r;
      assign src_r = rd_srcs[s*REG_W +: REG_W];
      assign dst_r = p_dst[p*REG_W +: REG_W];
      assign hit[s*NUM_PROD + p] = p_valid[p] && p_load[p] &&
                                   (src_r != '0) && (src_r == dst_r);
    end
  end

  assign stall = rd_valid && (|hit);

  // checks on the decode side
  p_idle_r5 : assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> !stall);
  p_reg0_r3 : assert property (@(posedge clk) disable iff (rst)
    (rd_srcs == '0) |-> !stall);
endmodule

// File: rtl/ilk_branch.sv
module ilk_branch
  import ilk_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            ex_valid,
  input  logic            ex_branch,
  input  logic            ex_taken,
  input  logic [PC_W-1:0] ex_target,
  output logic [SQ_W-1:0] squash,
  output logic            redir_valid,
  output logic [PC_W-1:0] redir_pc
);
  logic take;
  assign take = ex_valid && ex_branch && ex_taken;

  always_comb begin
    squash        = '0;
    squash[SQ_F1] = take;
    squash[SQ_F2] = take;
  end

  assign redir_valid = take;
  assign redir_pc    = take ? ex_target : '0;
endmodule

// File: rtl/ilk_unit.sv
module ilk_unit
  import ilk_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2,
  parameter int PC_W    = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_valid,
  input  logic [NUM_SRC*REG_W-1:0] rd_srcs,
  input  logic                     ex_valid,
  input  logic                     ex_load,
  input  logic [REG_W-1:0]         ex_dst,
  input  logic                     m1_valid,
  input  logic                     m1_load,
  input  logic [REG_W-1:0]         m1_dst,
  input  logic                     ex_branch,
  input  logic                     ex_taken,
  input  logic [PC_W-1:0]          ex_target,
  output logic                     stall,
  output logic [1:0]               squash,
  output logic                     redir_valid,
  output logic [PC_W-1:0]          redir_pc
);
  logic [NUM_PROD-1:0]       p_valid, p_load;
  logic [NUM_PROD*REG_W-1:0] p_dst;

  assign p_valid[PROD_EX] = ex_valid;
  assign p_valid[PROD_M1] = m1_valid;
  assign p_load[PROD_EX]  = ex_load;
  assign p_load[PROD_M1]  = m1_load;
  assign p_dst[PROD_EX*REG_W +: REG_W] = ex_dst;
  assign p_dst[PROD_M1*REG_W +: REG_W] = m1_dst;

  ilk_hazard #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_haz (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_srcs(rd_srcs),
    .p_valid(p_valid), .p_load(p_load), .p_dst(p_dst), .stall(stall)
  );

  ilk_branch #(.PC_W(PC_W)) u_br (
    .ex_valid(ex_valid), .ex_branch(ex_branch), .ex_taken(ex_taken),
    .ex_target(ex_target), .squash(squash),
    .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  logic [REG_W-1:0] src0;
  assign src0 = rd_srcs[REG_W-1:0];

  p_ex_load_r1 : assert property (@(posedge clk) disable iff (rst)
    (rd_valid && ex_valid && ex_load && src0 != '0 && src0 == ex_dst) |-> stall);
  p_m1_load_r2 : assert property (@(posedge clk) disable iff (rst)
    (rd_valid && m1_valid && m1_load && src0 != '0 && src0 == m1_dst) |-> stall);
  p_nolds_r4 : assert property (@(posedge clk) disable iff (rst)
    (!(ex_valid && ex_load) && !(m1_valid && m1_load)) |-> !stall);
  p_taken_r7 : assert property (@(posedge clk) disable iff (rst)
    (ex_valid && ex_branch && ex_taken) |->
      (squash == 2'b11 && redir_valid && redir_pc == ex_target));
  p_quiet_r8 : assert property (@(posedge clk) disable iff (rst)
    !(ex_valid && ex_branch && ex_taken) |-> (squash == 2'b00 && !redir_valid));
endmodule

// File: tb/ilk_unit_tb.sv
module ilk_unit_tb;
  logic clk = 0, rst = 1;
  always #4 clk = ~clk;

  logic        rd_valid, ex_valid, ex_load, m1_valid, m1_load;
  logic        ex_branch, ex_taken;
  logic [9:0]  rd_srcs;
  logic [4:0]  ex_dst, m1_dst;
  logic [31:0] ex_target;
  logic        stall, redir_valid;
  logic [1:0]  squash;
  logic [31:0] redir_pc;

  ilk_unit u_dut (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_srcs(rd_srcs),
    .ex_valid(ex_valid), .ex_load(ex_load), .ex_dst(ex_dst),
    .m1_valid(m1_valid), .m1_load(m1_load), .m1_dst(m1_dst),
    .ex_branch(ex_branch), .ex_taken(ex_taken), .ex_target(ex_target),
    .stall(stall), .squash(squash), .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  typedef struct {
    logic        st;
    logic [1:0]  sq;
    logic        rv;
    logic [31:0] pc;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rd_valid = 0; rd_srcs = '0; ex_valid = 0; ex_load = 0; ex_dst = '0;
    m1_valid = 0; m1_load = 0; m1_dst = '0;
    ex_branch = 0; ex_taken = 0; ex_target = '0;
  endtask

  // driver: apply one cycle of stimulus and queue the expected outputs
  task automatic drive(input logic rv, input logic [4:0] s0, input logic [4:0] s1,
                       input logic ev, input logic el, input logic [4:0] ed,
                       input logic mv, input logic ml, input logic [4:0] md,
                       input logic br, input logic tk, input logic [31:0] tg,
                       input logic est, input logic [1:0] esq, input logic erv,
                       input string tag);
    exp_t e;
    @(negedge clk);
    rd_valid = rv; rd_srcs = {s1, s0};
    ex_valid = ev; ex_load = el; ex_dst = ed;
    m1_valid = mv; m1_load = ml; m1_dst = md;
    ex_branch = br; ex_taken = tk; ex_target = tg;
    e.st = est; e.sq = esq; e.rv = erv; e.pc = tg; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: inputs change only at negedge, outputs settled by posedge
  always @(posedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " stall"}, 32'(stall), 32'(e.st));
      chk({e.tag, " squash"}, 32'(squash), 32'(e.sq));
      chk({e.tag, " redir"}, 32'(redir_valid), 32'(e.rv));
      if (e.rv) chk({e.tag, " pc"}, redir_pc, e.pc);
    end
  end

  // R9: small pipeline model around the unit; count stall cycles seen by consumer
  task automatic load_use(input int gap, input int exp_cnt, input string tag);
    int ld_stage = 0;   // 0=EX, 1=M1, 2=beyond
    int fill_left = gap;
    int cnt = 0;
    bit gone = 0;
    for (int k = 0; k < 8 && !gone; k++) begin
      @(negedge clk);
      idle();
      rd_valid = 1;
      rd_srcs  = (fill_left > 0) ? {5'd9, 5'd7} : {5'd3, 5'd12};
      if (ld_stage == 0) begin ex_valid = 1; ex_load = 1; ex_dst = 5'd12; end
      if (ld_stage == 1) begin m1_valid = 1; m1_load = 1; m1_dst = 5'd12; end
      #1;
      if (fill_left == 0) begin
        if (stall) cnt++;
        else gone = 1;
      end else if (!stall) fill_left--;
      ld_stage++;
    end
    chk(tag, 32'(cnt), 32'(exp_cnt));
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst = 0;
    // reset/idle state
    #1;
    chk("R5 idle stall", 32'(stall), 0);
    chk("R8 idle squash", 32'(squash), 0);
    // R1 load in EX matching source 0
    drive(1, 5'd4, 5'd0, 1, 1, 5'd4, 0, 0, 0, 0, 0, 0, 1, 2'b00, 0, "R1 ex load");
    // R2 load in M1 matching
    drive(1, 5'd6, 5'd1, 0, 0, 0, 1, 1, 5'd6, 0, 0, 0, 1, 2'b00, 0, "R2 m1 load");
    // R3 register 0 never hazards
    drive(1, 5'd0, 5'd0, 1, 1, 5'd0, 1, 1, 5'd0, 0, 0, 0, 0, 2'b00, 0, "R3 reg0");
    // R4 non-load producers and invalid loads
    drive(1, 5'd8, 5'd9, 1, 0, 5'd8, 1, 0, 5'd9, 0, 0, 0, 0, 2'b00, 0, "R4 alu prod");
    drive(1, 5'd8, 5'd9, 0, 1, 5'd8, 0, 1, 5'd9, 0, 0, 0, 0, 2'b00, 0, "R4 invalid prod");
    // R5 invalid consumer
    drive(0, 5'd8, 5'd9, 1, 1, 5'd8, 1, 1, 5'd9, 0, 0, 0, 0, 2'b00, 0, "R5 rd invalid");
    // R6 match on second field only
    drive(1, 5'd2, 5'd17, 1, 1, 5'd17, 0, 0, 0, 0, 0, 0, 1, 2'b00, 0, "R6 src1 ex");
    drive(1, 5'd2, 5'd31, 0, 0, 0, 1, 1, 5'd31, 0, 0, 0, 1, 2'b00, 0, "R6 src1 m1");
    drive(1, 5'd2, 5'd3, 1, 1, 5'd4, 1, 1, 5'd5, 0, 0, 0, 0, 2'b00, 0, "R6 no match");
    // R7 taken branch
    drive(1, 5'd2, 5'd3, 1, 0, 5'd1, 0, 0, 0, 1, 1, 32'h0000_4A10, 0, 2'b11, 1, "R7 taken");
    drive(1, 5'd6, 5'd3, 1, 0, 5'd1, 1, 1, 5'd6, 1, 1, 32'hFFFF_FFFC, 1, 2'b11, 1, "R7 taken with stall");
    // R8 not taken / not a branch / invalid
    drive(1, 5'd2, 5'd3, 1, 0, 5'd1, 0, 0, 0, 1, 0, 32'h1234, 0, 2'b00, 0, "R8 not taken");
    drive(1, 5'd2, 5'd3, 1, 0, 5'd1, 0, 0, 0, 0, 1, 32'h1234, 0, 2'b00, 0, "R8 not branch");
    drive(1, 5'd2, 5'd3, 0, 0, 5'd1, 0, 0, 0, 1, 1, 32'h1234, 0, 2'b00, 0, "R8 ex invalid");
    @(negedge clk); idle();
    wait (q.size() == 0);
    @(negedge clk);
    // R9 end-to-end stall lengths
    load_use(0, 2, "R9 distance1 stalls");
    load_use(1, 1, "R9 distance2 stalls");
    load_use(3, 0, "R9 distance4 stalls");
    @(negedge clk); idle();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule